// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block keeps one 64-bit machine time counter, shared by all harts, and one 64-bit compare register per hart. Each hart gets a level timer interrupt that is high while its compare value is at or below the current time. The counter advances by one on every clock where the tick-enable input is high. The timebase is produced elsewhere and reaches this block already in its clock domain.

Software reaches the counter and the compare registers through a simple register-bus slave port. The port carries either 4-byte or 8-byte accesses. A 4-byte write changes one 32-bit half of a register and keeps the other half. An 8-byte access moves the whole 64-bit value in one cycle, so it is never split. Writing the time counter moves the clock for every hart at once. Every interrupt is then compared again against the new time.

Read data is registered. Illegal, unmapped and out-of-range accesses are harmless: writes to them change nothing and reads from them return zero.

Top module: `hart_timer_unit`

## Requirements
- R1: `bus_size` = 0 selects a 4-byte access and `bus_size` = 1 an 8-byte access. An 8-byte write at a register's low address replaces all 64 bits in one cycle. An 8-byte read there returns all 64 bits at once.
- R2: The compare register of hart h sits at `CMP_BASE + 8*h`. Its low 32 bits are at offset 0 and its high 32 bits at offset 4. The time counter uses the same layout at `TIME_BASE`.
- R3: A 4-byte write to a compare register replaces only the addressed half and keeps the other half. A compare register never changes in a cycle without a bus write.
- R4: An 8-byte access at offset 4, or any access with `bus_addr[1:0]` not zero, is illegal. An illegal write changes nothing, and an illegal read returns zero.
- R5: A 4-byte read returns the addressed half in `bus_rdata[31:0]`, with `bus_rdata[63:32]` zero.
- R6: The time counter is writable. A 4-byte write to its low half keeps the upper 32 bits. A 4-byte write to its high half keeps the lower 32 bits. An 8-byte write loads the full value.
- R7: `timer_irq[h]` equals (compare[h] <= time) as it stood one clock earlier. This holds for every hart after any change of time or of a compare value.
- R8: Reset clears the time counter, the interrupt outputs and the read data to zero. Every compare register resets to all ones, so no interrupt is pending after reset.
- R9: A compare slot whose index is at or above `NUM_HARTS` ignores writes and reads as zero. Any unmapped address also reads as zero.
- R10: The time counter increments by one on each clock with `tick_en` high. A time write in the same cycle takes priority over the increment. Without a tick or a write, the time counter holds.
- R11: `bus_rdata` takes the result of a read on the clock that accepts the read. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick, advances the time counter |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 1 | 0 = 4 bytes, 1 = 8 bytes |
| bus_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| bus_rdata | output | 64 | Registered read data |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench builds the block with three harts in a four-slot compare window at 0x0040 and the time counter at 0x0100. Because the window is wider than the hart count, slot 3 decodes as a compare address but must be rejected, and 0x0200 stays fully unmapped. Compare writes are biased toward values a few ticks above the current time, so interrupts rise and fall many times during the random phase. Directed steps push the low half of the time counter across its 32-bit carry, and they collide a time write with a tick in the same cycle.

// File: rtl/htmr_pkg.sv
package htmr_pkg;

   localparam int unsigned REG_W  = 64;
   localparam int unsigned HALF_W = REG_W / 2;

   typedef enum logic {
      ACC_WORD  = 1'b0,
      ACC_DWORD = 1'b1
   } acc_size_e;

   typedef struct packed {
      logic legal;
      logic dword;
      logic upper;
   } acc_t;

   // Merge write data into a 64-bit register according to access shape.
   function automatic logic [REG_W-1:0] merge_write(
      input logic [REG_W-1:0] old_val,
      input logic [REG_W-1:0] wdata,
      input acc_t             acc
   );
      logic [REG_W-1:0] res;
      if (acc.dword)
         res = wdata;
      else if (acc.upper)
         res = {wdata[HALF_W-1:0], old_val[HALF_W-1:0]};
      else
         res = {old_val[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
      return res;
   endfunction

   // Shape a 64-bit register into the bus read view.
   function automatic logic [REG_W-1:0] read_view(
      input logic [REG_W-1:0] val,
      input acc_t             acc
   );
      logic [REG_W-1:0] res;
      if (acc.dword)
         res = val;
      else if (acc.upper)
         res = {{HALF_W{1'b0}}, val[REG_W-1:HALF_W]};
      else
         res = {{HALF_W{1'b0}}, val[HALF_W-1:0]};
      return res;
   endfunction

endpackage

// File: rtl/htmr_decode.sv
module htmr_decode
   import htmr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_HARTS = 2,
   parameter int unsigned CMP_SLOTS = 8,
   parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
   parameter logic [ADDR_W-1:0] TIME_BASE = {ADDR_W{1'b1}} << 3
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 size,
   output acc_t                 acc,
   output logic                 time_hit,
   output logic [NUM_HARTS-1:0] cmp_sel
);

   localparam int unsigned SLOT_W = ADDR_W - 3;
   localparam logic [SLOT_W-1:0] CMP_SLOT0  = CMP_BASE[ADDR_W-1:3];
   localparam logic [SLOT_W-1:0] TIME_SLOT  = TIME_BASE[ADDR_W-1:3];
   localparam logic [SLOT_W:0]   SLOT_LIMIT = (SLOT_W+1)'(CMP_SLOTS);

   // Elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_addr_w
      $error("htmr_decode: ADDR_W out of range");
   end
   if (NUM_HARTS < 1) begin : g_bad_harts
      $error("htmr_decode: NUM_HARTS must be at least 1");
   end
   if (CMP_SLOTS < NUM_HARTS) begin : g_bad_slots
      $error("htmr_decode: CMP_SLOTS smaller than NUM_HARTS");
   end
   if (CMP_BASE[2:0] != 3'b000 || TIME_BASE[2:0] != 3'b000) begin : g_bad_align
      $error("htmr_decode: bases must be 8-byte aligned");
   end
   if ((CMP_SLOTS + int'(CMP_SLOT0)) > (1 << SLOT_W)) begin : g_bad_span
      $error("htmr_decode: compare window exceeds address space");
   end
   if (TIME_SLOT >= CMP_SLOT0 &&
       int'(TIME_SLOT) < int'(CMP_SLOT0) + CMP_SLOTS) begin : g_bad_overlap
      $error("htmr_decode: time register overlaps compare window");
   end

   logic [SLOT_W-1:0] slot_addr;
   logic [SLOT_W-1:0] slot_off;
   logic              in_window;

   assign slot_addr = addr[ADDR_W-1:3];
   assign slot_off  = slot_addr - CMP_SLOT0;
   assign in_window = (slot_addr >= CMP_SLOT0) && ({1'b0, slot_off} < SLOT_LIMIT);

   assign acc.upper = addr[2];
   assign acc.dword = (size == ACC_DWORD);
   assign acc.legal = (addr[1:0] == 2'b00) && !(size == ACC_DWORD && addr[2]);

   assign time_hit = (slot_addr == TIME_SLOT);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
      assign cmp_sel[h] = in_window && (slot_off == SLOT_W'(h));
   end

endmodule

// File: rtl/htmr_time_ctr.sv
module htmr_time_ctr
   import htmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  acc_t             acc,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] time_q
);

   logic do_write;
   assign do_write = wr_en && acc.legal;

   always_ff @(posedge clk) begin
      if (!rst_n)
         time_q <= '0;
      else if (do_write)
         time_q <= merge_write(time_q, wdata, acc);
      else if (tick_en)
         time_q <= time_q + REG_W'(1);
   end

endmodule

// File: rtl/htmr_cmp_slot.sv
module htmr_cmp_slot
   import htmr_pkg::*;
#(
   parameter logic [REG_W-1:0] CMP_RESET      = '1,
   parameter bit               IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  acc_t             acc,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] time_val,
   output logic [REG_W-1:0] cmp_q,
   output logic             irq
);

   logic do_write;
   logic expired;

   assign do_write = wr_en && acc.legal;
   assign expired  = (cmp_q <= time_val);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmp_q <= CMP_RESET;
      else if (do_write)
         cmp_q <= merge_write(cmp_q, wdata, acc);
   end

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= expired;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = expired && rst_n;
   end

endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
   import htmr_pkg::*;
#(
   parameter int unsigned ADDR_W         = 16,
   parameter int unsigned NUM_HARTS      = 2,
   parameter int unsigned CMP_SLOTS      = 8,
   parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
   parameter logic [ADDR_W-1:0] TIME_BASE = {ADDR_W{1'b1}} << 3,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_size,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   output logic [NUM_HARTS-1:0] timer_irq
);

   localparam int unsigned FLAT_W = NUM_HARTS * REG_W;

   acc_t                 acc;
   logic                 time_hit;
   logic [NUM_HARTS-1:0] cmp_sel;
   logic                 wr_req;
   logic                 rd_req;
   logic [REG_W-1:0]     time_q;
   logic [FLAT_W-1:0]    cmp_flat;
   logic [REG_W-1:0]     rd_next;
   logic [REG_W-1:0]     rdata_q;

   assign wr_req = bus_valid && bus_write;
   assign rd_req = bus_valid && !bus_write;

   htmr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS),
      .CMP_SLOTS (CMP_SLOTS),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) u_decode (
      .addr     (bus_addr),
      .size     (bus_size),
      .acc      (acc),
      .time_hit (time_hit),
      .cmp_sel  (cmp_sel)
   );

   htmr_time_ctr u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_req && time_hit),
      .acc     (acc),
      .wdata   (bus_wdata),
      .time_q  (time_q)
   );

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      htmr_cmp_slot #(
         .CMP_RESET      ({REG_W{1'b1}}),
         .IRQ_REGISTERED (IRQ_REGISTERED)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_req && cmp_sel[h]),
         .acc      (acc),
         .wdata    (bus_wdata),
         .time_val (time_q),
         .cmp_q    (cmp_flat[h*REG_W +: REG_W]),
         .irq      (timer_irq[h])
      );
   end

   // Read mux: selects are one-hot or empty, so an OR reduction suffices.
   always_comb begin
      rd_next = '0;
      if (acc.legal) begin
         if (time_hit)
            rd_next = read_view(time_q, acc);
         for (int h = 0; h < NUM_HARTS; h++) begin
            if (cmp_sel[h])
               rd_next = rd_next | read_view(cmp_flat[h*REG_W +: REG_W], acc);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_req)
         rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/htmr_checker.sv
module htmr_checker #(
   parameter int unsigned NUM_HARTS      = 2,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick_en,
   input logic                    bus_valid,
   input logic                    bus_write,
   input logic [63:0]             time_val,
   input logic [NUM_HARTS*64-1:0] cmp_flat,
   input logic [63:0]             bus_rdata,
   input logic [NUM_HARTS-1:0]    timer_irq
);

   logic [NUM_HARTS-1:0] cmp_le;
   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_le
      assign cmp_le[h] = (cmp_flat[h*64 +: 64] <= time_val);
   end

   if (IRQ_REGISTERED) begin : g_irq_chk
      for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
         assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            timer_irq[h] == $past(cmp_le[h]));
      end
   end

   assert_tick_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !(bus_valid && bus_write)) |=> time_val == $past(time_val) + 64'd1);

   assert_time_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !(bus_valid && bus_write)) |=> $stable(time_val));

   assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(cmp_flat));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(bus_rdata));

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (time_val == 64'd0 && timer_irq == '0));

endmodule

bind hart_timer_unit htmr_checker #(
   .NUM_HARTS      (NUM_HARTS),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .time_val  (time_q),
   .cmp_flat  (cmp_flat),
   .bus_rdata (bus_rdata),
   .timer_irq (timer_irq)
);

// File: tb/hart_timer_unit_test.sv
`timescale 1ns/1ps
module hart_timer_unit_test;

   localparam int unsigned NH    = 3;
   localparam int unsigned SLOTS = 4;
   localparam logic [15:0] CMPB  = 16'h0040;
   localparam logic [15:0] TIMEB = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_size = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [NH-1:0] timer_irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [63:0] m_time;
   logic [63:0] m_cmp [NH];
   logic [63:0] exp_rd;

   always #4 clk = ~clk;

   hart_timer_unit #(
      .ADDR_W    (16),
      .NUM_HARTS (NH),
      .CMP_SLOTS (SLOTS),
      .CMP_BASE  (CMPB),
      .TIME_BASE (TIMEB)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .timer_irq (timer_irq)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit acc_ok(input logic [15:0] a, input logic sz);
      return (a[1:0] == 2'b00) && !(sz && a[2]);
   endfunction

   // -1 = time, 0..NH-1 = hart compare, -2 = nothing
   function automatic int target(input logic [15:0] a);
      int s;
      if (a[15:3] == TIMEB[15:3]) return -1;
      if (a >= CMPB && a < CMPB + 16'(SLOTS*8)) begin
         s = int'((a - CMPB) >> 3);
         if (s < NH) return s;
      end
      return -2;
   endfunction

   function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] w,
                                       input logic sz, input logic up);
      if (sz) return w;
      if (up) return {w[31:0], o[31:0]};
      return {o[63:32], w[31:0]};
   endfunction

   function automatic logic [63:0] model_read(input logic [15:0] a, input logic sz);
      int t;
      logic [63:0] v;
      if (!acc_ok(a, sz)) return 64'd0;
      t = target(a);
      if (t == -2) return 64'd0;
      v = (t == -1) ? m_time : m_cmp[t];
      if (sz) return v;
      return a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
   endfunction

   // One bus cycle: drive at negedge, update model, check after posedge.
   task automatic step(input bit v, input bit w, input logic [15:0] a,
                       input logic sz, input logic [63:0] wd, input bit tk,
                       input string tag);
      logic [NH-1:0] exp_irq;
      int t;
      bit rd;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = a; bus_size = sz;
      bus_wdata = wd; tick_en = tk;
      for (int h = 0; h < NH; h++) exp_irq[h] = (m_cmp[h] <= m_time);
      rd = v && !w;
      if (rd) exp_rd = model_read(a, sz);
      t = target(a);
      if (v && w && acc_ok(a, sz) && t == -1)
         m_time = mrg(m_time, wd, sz, a[2]);
      else if (tk)
         m_time = m_time + 64'd1;
      if (v && w && acc_ok(a, sz) && t >= 0)
         m_cmp[t] = mrg(m_cmp[t], wd, sz, a[2]);
      @(posedge clk);
      #1;
      check(timer_irq == exp_irq, "R7 irq", 64'(timer_irq), 64'(exp_irq));
      check(bus_rdata == exp_rd, rd ? tag : "R11 rdata hold", bus_rdata, exp_rd);
   endtask

   task automatic idle(input int n, input bit tk);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 1'b0, 64'd0, tk, "R11");
   endtask

   function automatic logic [15:0] cmp_addr(input int h, input bit up);
      return CMPB + 16'(h*8) + (up ? 16'd4 : 16'd0);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      m_time = '0;
      for (int h = 0; h < NH; h++) m_cmp[h] = '1;
      exp_rd = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: reset state
      check(bus_rdata == 64'd0, "R8 rdata after reset", bus_rdata, 64'd0);
      check(timer_irq == '0, "R8 irq after reset", 64'(timer_irq), 64'd0);
      step(1, 0, TIMEB, 1, 0, 0, "R8 time reads zero");
      step(1, 0, cmp_addr(0, 0), 1, 0, 0, "R8 compare reset all ones");
      check(bus_rdata == 64'hFFFF_FFFF_FFFF_FFFF, "R8 compare value", bus_rdata, '1);

      // R3 / R2 / R5: half writes to compare
      step(1, 1, cmp_addr(1, 0), 0, 64'hDEAD_0000_1111_2222, 0, "R3");
      step(1, 0, cmp_addr(1, 0), 1, 0, 0, "R3 low half merge");
      check(bus_rdata == 64'hFFFF_FFFF_1111_2222, "R3 low write keeps high", bus_rdata, 64'hFFFF_FFFF_1111_2222);
      step(1, 1, cmp_addr(1, 1), 0, 64'h0000_0000_AAAA_0000, 0, "R2");
      step(1, 0, cmp_addr(1, 1), 0, 0, 0, "R5 high half read");
      check(bus_rdata == 64'h0000_0000_AAAA_0000, "R2 high half at offset 4", bus_rdata, 64'hAAAA_0000);
      step(1, 0, cmp_addr(1, 0), 0, 0, 0, "R5 low half read");

      // R1: full 64-bit write and read
      step(1, 1, cmp_addr(2, 0), 1, 64'h0123_4567_89AB_CDEF, 0, "R1");
      step(1, 0, cmp_addr(2, 0), 1, 0, 0, "R1 dword read");
      check(bus_rdata == 64'h0123_4567_89AB_CDEF, "R1 dword value", bus_rdata, 64'h0123_4567_89AB_CDEF);

      // R4: illegal accesses
      step(1, 1, cmp_addr(2, 1), 1, 64'h5555_5555_5555_5555, 0, "R4");
      step(1, 1, cmp_addr(2, 0) + 16'd1, 0, 64'h7777_7777, 0, "R4");
      step(1, 0, cmp_addr(2, 0), 1, 0, 0, "R4 illegal writes ignored");
      step(1, 0, cmp_addr(2, 1), 1, 0, 0, "R4 dword at offset 4 reads zero");
      step(1, 0, TIMEB + 16'd4, 1, 0, 0, "R4 dword time at offset 4 reads zero");

      // R9: rejected slot and unmapped space
      step(1, 1, cmp_addr(3, 0), 1, 64'h1234, 0, "R9");
      step(1, 0, cmp_addr(3, 0), 1, 0, 0, "R9 out-of-range slot reads zero");
      step(1, 0, 16'h0200, 1, 0, 0, "R9 unmapped reads zero");
      for (int h = 0; h < NH; h++) step(1, 0, cmp_addr(h, 0), 1, 0, 0, "R9 other harts untouched");

      // R6 / R10: time writes, priority and carry
      step(1, 1, TIMEB, 0, 64'hFFFF_FFFF, 1, "R10");
      step(1, 0, TIMEB, 1, 0, 0, "R10 write wins over tick");
      check(bus_rdata == 64'h0000_0000_FFFF_FFFF, "R10 priority value", bus_rdata, 64'hFFFF_FFFF);
      idle(1, 1);
      step(1, 0, TIMEB + 16'd4, 0, 0, 0, "R6 carry into high half");
      check(bus_rdata == 64'd1, "R6 carry value", bus_rdata, 64'd1);
      step(1, 1, TIMEB + 16'd4, 0, 64'h5, 0, "R6");
      step(1, 0, TIMEB, 1, 0, 0, "R6 high write keeps low");
      step(1, 1, TIMEB, 1, 64'd0, 0, "R6");

      // R7: interrupts across all harts
      step(1, 1, cmp_addr(0, 0), 1, 64'd20, 0, "R7");
      step(1, 1, cmp_addr(1, 1), 0, 64'd0, 0, "R7");
      step(1, 1, cmp_addr(2, 0), 1, 64'd25, 0, "R7");
      idle(30, 1);
      step(1, 1, TIMEB, 1, 64'd3, 0, "R7 time moved back");
      idle(3, 0);

      // Random phase
      for (int i = 0; i < 3000; i++) begin
         int sel;
         logic [15:0] a;
         logic sz;
         logic [63:0] wd;
         bit w;
         sel = $urandom_range(0, 9);
         sz = 1'($urandom_range(0, 1));
         w = ($urandom_range(0, 2) != 0);
         case (sel)
            0, 1, 2, 3: a = cmp_addr(sel, 1'($urandom_range(0, 3) == 0));
            4, 5, 6:    a = TIMEB + (($urandom_range(0, 3) == 0) ? 16'd4 : 16'd0);
            7:          a = 16'h0200;
            8:          a = cmp_addr(0, 0) + 16'($urandom_range(1, 3));
            default:    a = cmp_addr($urandom_range(0, 2), 0);
         endcase
         if (sel <= 3 || sel == 9)
            wd = {32'd0, m_time[31:0] + 32'($urandom_range(0, 40))};
         else if ($urandom_range(0, 3) != 0)
            wd = 64'($urandom_range(0, 300));
         else
            wd = {$urandom, $urandom};
         step($urandom_range(0, 3) != 0, w, a, sz, wd, $urandom_range(0, 1) == 1,
              "R5 random read");
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule